// File: doc/BRIEF.md
# Drift-Corrected Time-of-Day Counter

This block keeps a nanosecond timebase for precision time protocol timestamping. While enabled, a free-running count advances by a programmable step on every clock. To trim the frequency of the timebase, a second step value is used in place of the normal one once every N counting clocks. This gives a fine average rate without any fractional arithmetic.

Software reaches the block through a small word-addressed register port. It can freeze a coherent snapshot of the running count, load a new absolute value for time steps, and choose a wrap period. When period wrapping is on, the count folds back by the period and keeps the excess. Each fold raises a one-clock pulse, and that pulse can also be routed to an output that feeds compare-channel logic.

Top module: `tod_counter`

## Requirements
- R1: After reset every register reads zero, and both `period_pulse_o` and `cmp_evt_o` are low.
- R2: While the enable bit (control register at address 0, bit 0) is clear, the count does not change.
- R3: While enabled, the count adds the normal step on every clock. The normal step is held in bits 6:0 of the step register at address 3.
- R4: With a correction interval N > 0 (address 4), every Nth counting clock adds the correction step instead of the normal step. The correction step is held in bits 14:8 of address 3. With N = 1, every clock uses the correction step.
- R5: A correction interval of zero disables correction, so only the normal step is used.
- R6: Writing the correction interval register restarts the interval count, so the next correction falls N counting clocks after the write.
- R7: Writing 1 to the capture bit (address 0, bit 2) copies the running count into the snapshot one clock later, and the capture bit then reads 0. Reads of address 1 return the snapshot, which stays unchanged until the next capture.
- R8: A write to address 1 loads the running count with the written value. No step is added in that clock.
- R9: With the wrap bit (address 0, bit 1) set and a non-zero period at address 2, a step that reaches or passes the period stores (count + step − period). A period of 0x8000_0000 therefore gives a 31-bit timebase.
- R10: Each wrap produces a one-clock high on `period_pulse_o`. With the wrap bit clear, the count rolls over modulo 2^32 and no pulse is produced.
- R11: `cmp_evt_o` repeats `period_pulse_o` only while the compare-route bit (address 0, bit 3) is set, and otherwise stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| period_pulse_o | output | 1 | One-clock pulse on every period wrap |
| cmp_evt_o | output | 1 | Wrap pulse routed to compare logic |

## Verification
The count is visible only through a capture, so a wrong internal state shows up as a wrong snapshot value at the first capture after the fault. Counting runs are scheduled so that the exact number of ticks, corrections and wraps between the enable write and the capture is known, and every result is a closed-form value. A stale correction interval count shows up as a correction step added earlier or later than expected within a run of a few clocks. A wrong fold shows up in the pulse count and in the residue left after the wrap.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_VALUE  = 3'd1,
    REG_PERIOD = 3'd2,
    REG_INCR   = 3'd3,
    REG_CORR   = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic pin;   // route wrap pulse to compare output
    logic cap;   // capture request, self-clearing
    logic prst;  // wrap at period
    logic en;    // count enable
  } ctrl_t;

  localparam int CTRL_W   = 4;
  localparam int CORR_LSB = 8;
endpackage

// File: rtl/tod_corr_sched.sv
`timescale 1ns/1ps
module tod_corr_sched #(
  parameter int CPER_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic [CPER_W-1:0] period_i,
  output logic              due_o
);
  logic [CPER_W-1:0] cnt_q;

  assign due_o = (period_i != '0) && (cnt_q == period_i - CPER_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= due_o ? '0 : cnt_q + CPER_W'(1);
  end

  AST_CORR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0); // R6
endmodule

// File: rtl/tod_accum.sv
`timescale 1ns/1ps
module tod_accum #(
  parameter int CNT_W = 32,
  parameter int INC_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             prst_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [INC_W-1:0] step_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             pulse_o
);
  logic [CNT_W-1:0] count_q;
  logic             pulse_q;
  logic [CNT_W:0]   sum;
  logic [CNT_W:0]   folded;
  logic             wrap;

  assign sum    = {1'b0, count_q} + (CNT_W+1)'(step_i);
  assign wrap   = prst_i && (period_i != '0) && (sum >= {1'b0, period_i});
  assign folded = sum - {1'b0, period_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      pulse_q <= 1'b0;
    end else if (load_i) begin
      count_q <= load_val_i;
      pulse_q <= 1'b0;
    end else if (en_i) begin
      count_q <= wrap ? folded[CNT_W-1:0] : sum[CNT_W-1:0];
      pulse_q <= wrap;
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign pulse_o = pulse_q;

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> count_q == $past(count_q)); // R2
  AST_LOAD_VAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_q == $past(load_val_i)); // R8
  AST_PULSE_NEEDS_PRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> $past(prst_i) && $past(en_i)); // R10
endmodule

// File: rtl/tod_counter.sv
`timescale 1ns/1ps
module tod_counter
  import tod_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int INC_W  = 7,
  parameter int CPER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  output logic             period_pulse_o,
  output logic             cmp_evt_o
);
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  period_q;
  logic [CNT_W-1:0]  snap_q;
  logic [INC_W-1:0]  norm_inc_q;
  logic [INC_W-1:0]  corr_inc_q;
  logic [CPER_W-1:0] cper_q;
  logic [CNT_W-1:0]  count;
  logic [INC_W-1:0]  step;
  logic              corr_due;
  logic              wr_ctrl, wr_value, wr_period, wr_incr, wr_corr;

  assign wr_ctrl   = reg_we_i && (reg_addr_i == REG_CTRL);
  assign wr_value  = reg_we_i && (reg_addr_i == REG_VALUE);
  assign wr_period = reg_we_i && (reg_addr_i == REG_PERIOD);
  assign wr_incr   = reg_we_i && (reg_addr_i == REG_INCR);
  assign wr_corr   = reg_we_i && (reg_addr_i == REG_CORR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      period_q   <= '0;
      norm_inc_q <= '0;
      corr_inc_q <= '0;
      cper_q     <= '0;
      snap_q     <= '0;
    end else begin
      if (wr_ctrl)        ctrl_q     <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
      else if (ctrl_q.cap) ctrl_q.cap <= 1'b0;
      if (ctrl_q.cap)     snap_q     <= count;
      if (wr_period)      period_q   <= reg_wdata_i;
      if (wr_incr) begin
        norm_inc_q <= reg_wdata_i[INC_W-1:0];
        corr_inc_q <= reg_wdata_i[CORR_LSB +: INC_W];
      end
      if (wr_corr)        cper_q     <= reg_wdata_i[CPER_W-1:0];
    end
  end

  tod_corr_sched #(.CPER_W(CPER_W)) u_sched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (ctrl_q.en),
    .restart_i (wr_corr),
    .period_i  (cper_q),
    .due_o     (corr_due)
  );

  assign step = corr_due ? corr_inc_q : norm_inc_q;

  tod_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl_q.en),
    .prst_i     (ctrl_q.prst),
    .period_i   (period_q),
    .step_i     (step),
    .load_i     (wr_value),
    .load_val_i (reg_wdata_i),
    .count_o    (count),
    .pulse_o    (period_pulse_o)
  );

  assign cmp_evt_o = period_pulse_o && ctrl_q.pin;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_CTRL:   reg_rdata_o[CTRL_W-1:0] = ctrl_q;
      REG_VALUE:  reg_rdata_o = snap_q;
      REG_PERIOD: reg_rdata_o = period_q;
      REG_INCR: begin
        reg_rdata_o[INC_W-1:0]          = norm_inc_q;
        reg_rdata_o[CORR_LSB +: INC_W]  = corr_inc_q;
      end
      REG_CORR:   reg_rdata_o[CPER_W-1:0] = cper_q;
      default:    reg_rdata_o = '0;
    endcase
  end

  AST_CAP_SELF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.cap && !wr_ctrl) |=> !ctrl_q.cap); // R7
  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.cap |=> snap_q == $past(snap_q)); // R7
  AST_CORR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cper_q == '0) |-> !corr_due); // R5
  AST_CMP_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_evt_o |-> period_pulse_o); // R11
endmodule

// File: tb/tod_counter_bench.sv
`timescale 1ns/1ps
module tod_counter_bench;
  localparam logic [2:0] A_CTRL = 3'd0, A_VALUE = 3'd1, A_PERIOD = 3'd2,
                         A_INCR = 3'd3, A_CORR = 3'd4;
  localparam logic [31:0] EN = 32'h1, PRST = 32'h2, CAP = 32'h4, PIN = 32'h8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pulse, cmp;

  int tests = 0;
  int fails = 0;
  int pulse_cnt = 0;
  int cmp_cnt = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t exp_q[$];
  event  rd_ev, mon_done;

  always #2 clk = ~clk;

  tod_counter u_tod_counter (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .period_pulse_o(pulse), .cmp_evt_o(cmp)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pop expected item, compare with read data
  initial forever begin
    item_t it;
    @(rd_ev);
    #0.5;
    it = exp_q.pop_front();
    check(it.tag, rdata, it.exp);
    -> mon_done;
  end

  initial forever begin
    @(negedge clk);
    #0.25;
    if (pulse) pulse_cnt++;
    if (cmp) cmp_cnt++;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    addr = a;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    -> rd_ev;
    @(mon_done);
    @(negedge clk);
  endtask

  // enable with flags, K idle clocks, stop and capture: K+1 counting clocks
  task automatic run_snap(input logic [31:0] flags, input int k);
    wr(A_CTRL, EN | flags);
    idle(k);
    wr(A_CTRL, CAP | flags);
    idle(1);
  endtask

  task automatic setup(input logic [31:0] v, input logic [31:0] inc, input logic [31:0] cper);
    wr(A_CTRL, 32'h0);
    wr(A_VALUE, v);
    wr(A_INCR, inc);
    wr(A_CORR, cper);
    pulse_cnt = 0;
    cmp_cnt = 0;
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_rd(A_CTRL,   32'h0, "R1 ctrl");
    expect_rd(A_VALUE,  32'h0, "R1 value");
    expect_rd(A_PERIOD, 32'h0, "R1 period");
    expect_rd(A_INCR,   32'h0, "R1 incr");
    expect_rd(A_CORR,   32'h0, "R1 corr");
    check("R1 pulses", {pulse, cmp}, 32'h0);

    // R2/R8: disabled, loaded value is captured unchanged
    setup(32'd100, 32'd5, 32'd0);
    idle(5);
    wr(A_CTRL, CAP);
    idle(1);
    expect_rd(A_VALUE, 32'd100, "R2 R8 frozen load");

    // R3: 10 ticks of 5
    setup(32'd0, 32'd5, 32'd0);
    run_snap(32'h0, 9);
    expect_rd(A_VALUE, 32'd50, "R3 normal step");
    expect_rd(A_CTRL, 32'h0, "R7 capture self-clear");
    wr(A_CTRL, EN);
    idle(5);
    wr(A_CTRL, 32'h0);
    expect_rd(A_VALUE, 32'd50, "R7 snapshot stable");

    // R4: norm 4, corr 10, N=3, 9 ticks -> 6*4 + 3*10
    setup(32'd0, 32'h0000_0A04, 32'd3);
    expect_rd(A_INCR, 32'h0000_0A04, "R4 step fields");
    run_snap(32'h0, 8);
    expect_rd(A_VALUE, 32'd54, "R4 corr every 3");
    setup(32'd0, 32'h0000_0A04, 32'd1);
    run_snap(32'h0, 4);
    expect_rd(A_VALUE, 32'd50, "R4 corr every clock");

    // R5: N=0
    setup(32'd0, 32'h0000_0A04, 32'd0);
    run_snap(32'h0, 8);
    expect_rd(A_VALUE, 32'd36, "R5 corr disabled");

    // R6: rewrite N each clock, no correction within 3 ticks
    setup(32'd0, 32'h0000_0A04, 32'd3);
    wr(A_CTRL, EN);
    wr(A_CORR, 32'd3);
    wr(A_CORR, 32'd3);
    wr(A_CTRL, CAP);
    idle(1);
    expect_rd(A_VALUE, 32'd12, "R6 interval restart");

    // R9/R10: period 100, step 7, 30 ticks
    wr(A_PERIOD, 32'd100);
    setup(32'd0, 32'd7, 32'd0);
    run_snap(PRST, 29);
    expect_rd(A_VALUE, 32'd10, "R9 fold keeps excess");
    check("R10 pulse count", pulse_cnt, 32'd2);
    check("R11 cmp off", cmp_cnt, 32'd0);

    // R11: routed to compare output
    setup(32'd0, 32'd7, 32'd0);
    run_snap(PRST | PIN, 29);
    expect_rd(A_VALUE, 32'd10, "R11 value");
    check("R11 cmp count", cmp_cnt, 32'd2);
    check("R11 pulse count", pulse_cnt, 32'd2);

    // R9: 31-bit timebase
    wr(A_PERIOD, 32'h8000_0000);
    setup(32'h7FFF_FFFC, 32'd8, 32'd0);
    run_snap(PRST, 0);
    expect_rd(A_VALUE, 32'd4, "R9 31-bit wrap");
    check("R10 wrap pulse", pulse_cnt, 32'd1);

    // R10: no wrap bit, full-width rollover, no pulse
    setup(32'hFFFF_FFFC, 32'd8, 32'd0);
    run_snap(32'h0, 0);
    expect_rd(A_VALUE, 32'd4, "R10 full rollover");
    check("R10 no pulse", pulse_cnt, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule